// File: doc/BRIEF.md
# Logical-to-Engine Channel Allocator

This block shares a small pool of physical transfer engines among a larger set of logical request channels. A channel that has work asks for service. If it holds no engine and is not already waiting, it is appended to a first-come waiting queue. Every clock cycle the allocator runs one binding pass. Each engine that was idle at the start of the cycle takes the oldest waiting channel, and engines are visited from index 0 upward. The block publishes the binding table: a bound flag and a channel number per engine. It also gives each engine a start pulse once its binding is in place and a stop pulse when a terminate tears the binding down.

An engine is handed back when it reports completion and its channel has no remaining work, or when its channel is terminated. A channel can be paused and resumed. Pausing a waiting channel takes it out of the queue. Resuming it puts it back only if it still has work. No data moves through this block. All pins are plain single-cycle control pulses or level status, so there is no valid/ready handshake and no back-pressure. The queue can never overflow, because each channel occupies at most one slot.

Top module: `chan_alloc`

## Requirements
- R1: After reset no engine is bound, `eng_start` and `eng_stop` are all zero, the waiting queue is empty, and no channel is paused.
- R2: An issue pulse from a channel that is unpaused, unbound and not waiting appends it to the queue tail. An issue from a channel that is already bound or already waiting has no effect, so it never occupies two slots.
- R3: In each cycle, every engine that was unbound at the start of the cycle takes the oldest waiting channel, lowest engine index first. A channel whose issue is sampled at clock edge N is bound at edge N+1 if an engine is free.
- R4: `eng_start[e]` is high for exactly the one cycle that follows the first cycle in which engine e shows a new binding.
- R5: A pulse on `eng_done[e]` for a bound engine whose channel has `ch_has_work` low frees the engine at that edge. If `ch_has_work` is high, the binding is kept.
- R6: `ch_term` on a bound channel clears the binding at that edge and pulses `eng_stop` for that engine in the same cycle the binding drops. The engine may be rebound at the next edge. `ch_term` on a waiting channel removes it from the queue.
- R7: `ch_pause` on a waiting channel removes it from the queue. On a bound channel it leaves the binding unchanged.
- R8: `ch_resume` on a paused channel whose `ch_has_work` is high re-appends it to the queue. With `ch_has_work` low, the channel is not queued.
- R9: Several channels issuing in the same cycle are appended in ascending channel number.
- R10: An issue from a paused channel, or from a channel pausing in the same cycle, is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ch_issue | input | NUM_CH | Per-channel request pulse for service |
| ch_has_work | input | NUM_CH | Per-channel level: descriptors remain |
| ch_pause | input | NUM_CH | Per-channel pause pulse |
| ch_resume | input | NUM_CH | Per-channel resume pulse |
| ch_term | input | NUM_CH | Per-channel terminate pulse |
| eng_done | input | NUM_ENG | Per-engine completion pulse |
| eng_bound | output | NUM_ENG | Engine currently owns a channel |
| eng_ch | output | NUM_ENG*CHW | Channel number per engine, engine e at bits [e*CHW +: CHW] |
| eng_start | output | NUM_ENG | One-cycle start pulse per engine |
| eng_stop | output | NUM_ENG | One-cycle stop pulse on terminate |

## Verification
The embedded properties assume every control input is a single-cycle pulse or a level that is stable between edges. They also assume `ch_has_work` truthfully reports a channel's remaining descriptors. Some inputs can be meaningless, such as done on an idle engine or resume on an unpaused channel. The properties tolerate these, because the design simply ignores them. The stimulus changes inputs only on falling edges, holds every pulse for exactly one cycle, and raises `ch_has_work` for a channel before or together with its issue. It drops `ch_has_work` only when the bench intends that channel to be released.

// File: rtl/alloc_pkg.sv
package alloc_pkg;
  localparam int DEF_NUM_CH  = 16;
  localparam int DEF_NUM_ENG = 6;

  function automatic int bits_for(input int n);
    return (n <= 1) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/alloc_pend_queue.sv
module alloc_pend_queue
  import alloc_pkg::*;
#(
  parameter int NUM_CH  = DEF_NUM_CH,
  parameter int NUM_ENG = DEF_NUM_ENG
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [NUM_CH-1:0]                 remove,
  input  logic [NUM_CH-1:0]                 append,
  input  logic [$clog2(NUM_ENG+1)-1:0]      pop_n,
  output logic [NUM_ENG-1:0][bits_for(NUM_CH)-1:0] head_ch,
  output logic [NUM_ENG-1:0]                head_vld,
  output logic [NUM_CH-1:0]                 in_q
);
  localparam int CHW  = bits_for(NUM_CH);
  localparam int CNTW = $clog2(NUM_CH + 1);
  localparam int PW   = $clog2(NUM_ENG + 1);

  logic [NUM_CH-1:0][CHW-1:0] ent_q;
  logic [NUM_CH-1:0][CHW-1:0] cmp;
  logic [NUM_CH-1:0][CHW-1:0] nxt;
  logic [CNTW-1:0]            cnt_q;
  logic [CNTW-1:0]            ccnt;
  logic [CNTW-1:0]            ncnt;
  logic [NUM_CH-1:0]          memb_q;
  logic [NUM_CH-1:0]          memb_n;
  logic [NUM_CH-1:0]          popm;

  // Stage 1: drop paused/terminated entries, keep order
  always_comb begin
    cmp  = '0;
    ccnt = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (CNTW'(i) < cnt_q && !remove[ent_q[i]]) begin
        cmp[ccnt[CHW-1:0]] = ent_q[i];
        ccnt = ccnt + 1'b1;
      end
    end
  end

  for (genvar h = 0; h < NUM_ENG; h++) begin : g_head
    assign head_ch[h]  = cmp[h];
    assign head_vld[h] = (CNTW'(h) < ccnt);
  end

  // Stage 2: pop heads taken by engines, then append new requests ascending
  always_comb begin
    nxt = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (i + int'(pop_n) < NUM_CH) nxt[i] = cmp[i + int'(pop_n)];
    end
    ncnt = ccnt - CNTW'(pop_n);
    for (int c = 0; c < NUM_CH; c++) begin
      if (append[c] && ncnt < CNTW'(NUM_CH)) begin
        nxt[ncnt[CHW-1:0]] = CHW'(c);
        ncnt = ncnt + 1'b1;
      end
    end
    popm = '0;
    for (int h = 0; h < NUM_ENG; h++) begin
      if (PW'(h) < pop_n) popm[cmp[h]] = 1'b1;
    end
    memb_n = (memb_q & ~remove & ~popm) | append;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent_q  <= '0;
      cnt_q  <= '0;
      memb_q <= '0;
    end else begin
      ent_q  <= nxt;
      cnt_q  <= ncnt;
      memb_q <= memb_n;
    end
  end

  assign in_q = memb_q;

  // Slot count and membership vector are kept separately; they must agree (no duplicates)
  assert_len_matches_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q == CNTW'($countones(memb_q)));

  // Caller never appends a channel that is already waiting
  assert_no_dup_append_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (append & memb_q) == '0);

  // Never pop more than the surviving entries
  assert_pop_bounded_R3: assert property (@(posedge clk) disable iff (!rst_n)
    CNTW'(pop_n) <= ccnt);
endmodule

// File: rtl/alloc_bind_table.sv
module alloc_bind_table
  import alloc_pkg::*;
#(
  parameter int NUM_CH  = DEF_NUM_CH,
  parameter int NUM_ENG = DEF_NUM_ENG
) (
  input  logic                                     clk,
  input  logic                                     rst_n,
  input  logic [NUM_ENG-1:0][bits_for(NUM_CH)-1:0] head_ch,
  input  logic [NUM_ENG-1:0]                       head_vld,
  input  logic [NUM_ENG-1:0]                       eng_done,
  input  logic [NUM_CH-1:0]                        ch_has_work,
  input  logic [NUM_CH-1:0]                        ch_term,
  output logic [$clog2(NUM_ENG+1)-1:0]             pop_n,
  output logic [NUM_ENG-1:0]                       eng_bound,
  output logic [NUM_ENG-1:0][bits_for(NUM_CH)-1:0] eng_ch,
  output logic [NUM_ENG-1:0]                       eng_start,
  output logic [NUM_ENG-1:0]                       eng_stop,
  output logic [NUM_CH-1:0]                        ch_bound
);
  localparam int CHW = bits_for(NUM_CH);
  localparam int PW  = $clog2(NUM_ENG + 1);

  logic [NUM_ENG-1:0]           bound_q;
  logic [NUM_ENG-1:0][CHW-1:0]  ch_q;
  logic [NUM_ENG-1:0][CHW-1:0]  new_ch;
  logic [NUM_ENG-1:0]           take;
  logic [NUM_ENG-1:0]           take_q;
  logic [NUM_ENG-1:0]           start_q;
  logic [NUM_ENG-1:0]           stop_q;
  logic [NUM_ENG-1:0]           rel;
  logic [NUM_ENG-1:0]           kill;
  int                           rank;

  // Allocation pass: free engines, ascending, take queue heads in order
  always_comb begin
    rank   = 0;
    take   = '0;
    new_ch = '0;
    for (int e = 0; e < NUM_ENG; e++) begin
      if (!bound_q[e] && rank < NUM_ENG) begin
        if (head_vld[rank]) begin
          take[e]   = 1'b1;
          new_ch[e] = head_ch[rank];
          rank      = rank + 1;
        end
      end
    end
    pop_n = PW'(rank);
  end

  always_comb begin
    ch_bound = '0;
    for (int e = 0; e < NUM_ENG; e++) begin
      rel[e]  = bound_q[e] & eng_done[e] & ~ch_has_work[ch_q[e]];
      kill[e] = bound_q[e] & ch_term[ch_q[e]];
      if (bound_q[e]) ch_bound[ch_q[e]] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bound_q <= '0;
      ch_q    <= '0;
      take_q  <= '0;
      start_q <= '0;
      stop_q  <= '0;
    end else begin
      for (int e = 0; e < NUM_ENG; e++) begin
        if (take[e]) begin
          bound_q[e] <= 1'b1;
          ch_q[e]    <= new_ch[e];
        end else if (rel[e] || kill[e]) begin
          bound_q[e] <= 1'b0;
          ch_q[e]    <= '0;
        end
      end
      take_q  <= take;
      start_q <= take_q;
      stop_q  <= kill;
    end
  end

  assign eng_bound = bound_q;
  assign eng_ch    = ch_q;
  assign eng_start = start_q;
  assign eng_stop  = stop_q;

  for (genvar e = 0; e < NUM_ENG; e++) begin : g_chk
    assert_start_after_bind_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bound_q[e]) |=> eng_start[e]);

    assert_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_done[e] && bound_q[e] && !ch_has_work[ch_q[e]]) |=> !bound_q[e]);

    assert_keep_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (bound_q[e] && !ch_term[ch_q[e]]) |=> (bound_q[e] && $stable(ch_q[e])) || !$past(ch_has_work[ch_q[e]]) );

    assert_stop_drops_R6: assert property (@(posedge clk) disable iff (!rst_n)
      eng_stop[e] |-> (!bound_q[e] && $past(bound_q[e])));

    if (e > 0) begin : g_ord
      assert_low_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
        take[e] |-> &(take[e-1:0] | bound_q[e-1:0]));
    end
  end
endmodule

// File: rtl/chan_alloc.sv
module chan_alloc
  import alloc_pkg::*;
#(
  parameter int NUM_CH  = DEF_NUM_CH,
  parameter int NUM_ENG = DEF_NUM_ENG,
  localparam int CHW    = bits_for(NUM_CH)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NUM_CH-1:0]       ch_issue,
  input  logic [NUM_CH-1:0]       ch_has_work,
  input  logic [NUM_CH-1:0]       ch_pause,
  input  logic [NUM_CH-1:0]       ch_resume,
  input  logic [NUM_CH-1:0]       ch_term,
  input  logic [NUM_ENG-1:0]      eng_done,
  output logic [NUM_ENG-1:0]      eng_bound,
  output logic [NUM_ENG*CHW-1:0]  eng_ch,
  output logic [NUM_ENG-1:0]      eng_start,
  output logic [NUM_ENG-1:0]      eng_stop
);
  localparam int PW = $clog2(NUM_ENG + 1);

  logic [NUM_CH-1:0]                paused_q;
  logic [NUM_CH-1:0]                in_q;
  logic [NUM_CH-1:0]                ch_bound;
  logic [NUM_CH-1:0]                want;
  logic [NUM_CH-1:0]                append;
  logic [NUM_CH-1:0]                remove;
  logic [NUM_ENG-1:0][CHW-1:0]      head_ch;
  logic [NUM_ENG-1:0]               head_vld;
  logic [NUM_ENG-1:0][CHW-1:0]      tbl_ch;
  logic [PW-1:0]                    pop_n;

  // Request filter: terminate beats pause beats resume/issue
  always_comb begin
    want   = (ch_issue & ~paused_q) | (ch_resume & paused_q & ch_has_work);
    append = want & ~ch_pause & ~ch_term & ~ch_bound & ~in_q;
    remove = ch_term | ch_pause;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) paused_q <= '0;
    else        paused_q <= ~ch_term & (ch_pause | (paused_q & ~ch_resume));
  end

  alloc_pend_queue #(.NUM_CH(NUM_CH), .NUM_ENG(NUM_ENG)) u_queue (
    .clk      (clk),
    .rst_n    (rst_n),
    .remove   (remove),
    .append   (append),
    .pop_n    (pop_n),
    .head_ch  (head_ch),
    .head_vld (head_vld),
    .in_q     (in_q)
  );

  alloc_bind_table #(.NUM_CH(NUM_CH), .NUM_ENG(NUM_ENG)) u_table (
    .clk         (clk),
    .rst_n       (rst_n),
    .head_ch     (head_ch),
    .head_vld    (head_vld),
    .eng_done    (eng_done),
    .ch_has_work (ch_has_work),
    .ch_term     (ch_term),
    .pop_n       (pop_n),
    .eng_bound   (eng_bound),
    .eng_ch      (tbl_ch),
    .eng_start   (eng_start),
    .eng_stop    (eng_stop),
    .ch_bound    (ch_bound)
  );

  assign eng_ch = tbl_ch;

  // A channel is either waiting or bound, never both
  assert_bound_not_queued_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_bound & in_q) == '0);

  // Paused channels never sit in the queue
  assert_paused_not_queued_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (paused_q & in_q) == '0);

  // Resume without remaining work never enqueues
  assert_resume_needs_work_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_resume & paused_q & ~ch_has_work & ~ch_issue & append) == '0);

  // After reset the table is empty and quiet
  assert_reset_quiet_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> (eng_bound == '0 && eng_start == '0 && eng_stop == '0 && in_q == '0));
endmodule

// File: tb/sim_chan_alloc.sv
module sim_chan_alloc;
  localparam int NCH = 16;
  localparam int NEN = 6;
  localparam int NVEC = 8;
  localparam logic [15:0] VEC [0:NVEC-1] = '{16'h0001, 16'h8000, 16'h003F, 16'hFFFF,
                                             16'hA5A5, 16'h0F00, 16'h8001, 16'h7FC0};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NCH-1:0] issue = '0, work = '0, pause = '0, resume = '0, term = '0;
  logic [NEN-1:0] done = '0;
  logic [NEN-1:0] eng_bound, eng_start, eng_stop;
  logic [NEN*4-1:0] eng_ch;
  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  chan_alloc #(.NUM_CH(NCH), .NUM_ENG(NEN)) u0 (
    .clk(clk), .rst_n(rst_n), .ch_issue(issue), .ch_has_work(work),
    .ch_pause(pause), .ch_resume(resume), .ch_term(term), .eng_done(done),
    .eng_bound(eng_bound), .eng_ch(eng_ch), .eng_start(eng_start), .eng_stop(eng_stop));

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] chof(input int e);
    return eng_ch[e*4 +: 4];
  endfunction

  task automatic do_reset();
    rst_n = 1'b0; issue = '0; work = '0; pause = '0; resume = '0; term = '0; done = '0;
    repeat (3) step();
    rst_n = 1'b1;
    step();
  endtask

  task automatic bind6();
    issue = 16'h003F; work = work | 16'h003F; step();
    issue = '0; step();
  endtask

  initial begin
    #400000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [NEN-1:0] eb1, eb2;
    logic [3:0] ec1 [NEN];
    logic [3:0] ec2 [NEN];
    int k;

    // R1: reset state
    do_reset();
    chk(eng_bound == '0, "R1 bound", 32'(eng_bound), 0);
    chk(eng_start == '0 && eng_stop == '0, "R1 pulses", 32'({eng_start, eng_stop}), 0);
    done = '1; step(); done = '0; step();
    chk(eng_bound == '0, "R1 queue empty", 32'(eng_bound), 0);

    // Vector table: R3/R9 ordering, R4 start, R5 release, second wave
    for (int v = 0; v < NVEC; v++) begin
      do_reset();
      eb1 = '0; eb2 = '0; k = 0;
      for (int e = 0; e < NEN; e++) begin ec1[e] = '0; ec2[e] = '0; end
      for (int c = 0; c < NCH; c++) begin
        if (VEC[v][c]) begin
          if (k < NEN) begin eb1[k] = 1'b1; ec1[k] = 4'(c); end
          else if (k < 2*NEN) begin eb2[k-NEN] = 1'b1; ec2[k-NEN] = 4'(c); end
          k++;
        end
      end
      issue = VEC[v]; work = VEC[v]; step();
      issue = '0; step();
      chk(eng_bound == eb1, "R3 first wave", 32'(eng_bound), 32'(eb1));
      for (int e = 0; e < NEN; e++)
        if (eb1[e]) chk(chof(e) == ec1[e], "R9 channel order", 32'(chof(e)), 32'(ec1[e]));
      step();
      chk(eng_start == eb1, "R4 start pulse", 32'(eng_start), 32'(eb1));
      work = '0; done = '1; step(); done = '0;
      chk(eng_bound == '0, "R5 release", 32'(eng_bound), 0);
      step();
      chk(eng_bound == eb2, "R3 second wave", 32'(eng_bound), 32'(eb2));
      for (int e = 0; e < NEN; e++)
        if (eb2[e]) chk(chof(e) == ec2[e], "R9 second wave order", 32'(chof(e)), 32'(ec2[e]));
    end

    // R2: duplicate suppression
    do_reset(); bind6();
    issue = 16'h0200; work = work | 16'h0600; step();
    issue = 16'h0200; step();
    issue = 16'h0404; step();
    issue = '0;
    work = work & ~16'h003F; done = '1; step(); done = '0;
    chk(eng_bound == '0, "R5 release all", 32'(eng_bound), 0);
    step();
    chk(eng_bound == 6'b000011, "R2 no duplicate", 32'(eng_bound), 32'h3);
    chk(chof(0) == 4'd9 && chof(1) == 4'd10, "R2 order", 32'({chof(1), chof(0)}), 32'hA9);

    // R5: done with remaining work keeps the binding
    do_reset(); bind6();
    done = 6'b001000; step(); done = '0;
    chk(eng_bound == 6'h3F && chof(3) == 4'd3, "R5 keep", 32'({chof(3), 2'b0, eng_bound}), 32'h33F);

    // R6: terminate bound and queued channels
    do_reset(); bind6();
    issue = 16'h0180; work = work | 16'h0180; step();
    issue = '0; term = 16'h0110; step(); term = '0;
    chk(eng_bound == 6'b101111, "R6 cleared", 32'(eng_bound), 32'h2F);
    chk(eng_stop == 6'b010000, "R6 stop pulse", 32'(eng_stop), 32'h10);
    step();
    chk(eng_bound == 6'h3F && chof(4) == 4'd7, "R6 rebind", 32'({chof(4), 2'b0, eng_bound}), 32'h73F);
    chk(eng_stop == '0, "R6 stop single", 32'(eng_stop), 0);
    step();
    chk(eng_start == 6'b010000, "R4 start after rebind", 32'(eng_start), 32'h10);
    work[0] = 1'b0; done = 6'b000001; step(); done = '0; step();
    chk(eng_bound[0] == 1'b0, "R6 queued removed", 32'(eng_bound), 32'h3E);

    // R7, R10, R8: pause / resume
    do_reset(); bind6();
    issue = 16'h3800; work = work | 16'h3800; step();
    issue = '0; pause = 16'h5002; step(); pause = '0;
    chk(eng_bound == 6'h3F && chof(1) == 4'd1, "R7 bound keeps", 32'({chof(1), 2'b0, eng_bound}), 32'h13F);
    issue = 16'h1000; step(); issue = '0;
    work[0] = 1'b0; work[1] = 1'b0; done = 6'b000011; step(); done = '0; step();
    chk(eng_bound == 6'h3F, "R7 rebound", 32'(eng_bound), 32'h3F);
    chk(chof(0) == 4'd11 && chof(1) == 4'd13, "R7 R10 paused skipped",
        32'({chof(1), chof(0)}), 32'hDB);
    resume = 16'h5000; work[14] = 1'b0; step(); resume = '0;
    work[2] = 1'b0; work[3] = 1'b0; done = 6'b001100; step(); done = '0; step();
    chk(eng_bound == 6'b110111, "R8 resume needs work", 32'(eng_bound), 32'h37);
    chk(chof(2) == 4'd12, "R8 resumed channel", 32'(chof(2)), 32'hC);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule